// File: doc/BRIEF.md
# Ripple Two's-Complement Negation Unit

This block produces the arithmetic negative of a signed word. It inverts every bit of the operand and adds one. The addition is done by a chain of identical one-bit cells. Each cell passes its carry to the next more significant cell. A constant one enters as the carry of the least significant cell, and no other carry input exists.

The operand width is a parameter with a default of four bits. A flag marks the single operand whose negative cannot be represented, which is the word with only its sign bit set. The final carry of the chain is also brought out. It is set only when the operand is zero.

The result can be taken straight from the chain, or through one register stage chosen by a parameter. The default uses the register stage. The register stage clears on an asynchronous active-low reset.

Top module: `negRipple`

## Requirements
- R1: For every N-bit operand `b`, `s` equals (2^N - b) mod 2^N, which is the bitwise inverse of `b` plus one.
- R2: `cout` is the carry leaving the most significant cell of a chain whose least significant carry-in is fixed at 1. It is 1 exactly when `b` is all zeros.
- R3: `ovf` is 0 for every operand other than the most negative one.
- R4: For the most negative operand (bit N-1 set, all other bits clear; 4'b1000 at the default width), `s` equals the operand and `ovf` is 1.
- R5: An all-zero operand gives `s` = 0, `cout` = 1 and `ovf` = 0.
- R6: With REG_OUT = 1 (the default), `s`, `cout` and `ovf` change only at a rising clock edge. They reflect the operand sampled at that edge, so they are stable between edges. With REG_OUT = 0, the outputs are combinational.
- R7: While `rstN` is low with REG_OUT = 1, `s`, `cout` and `ovf` are all 0, regardless of the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset of the output register |
| b | input | N | Signed operand |
| s | output | N | Negated operand |
| cout | output | 1 | Carry out of the most significant cell |
| ovf | output | 1 | Set when the operand has no representable negative |

## Verification
The bench walks every operand upward and then downward, and interleaves zero with the most negative word. These are the two ends of the carry chain. A cell that sums without inverting, or a chain with a missing carry seed, gives `s` equal to `b` or off by one on most inputs. A chain whose carry does not reach the top cell gives `cout` low for zero. A detector that tests only the sign bit raises `ovf` for every negative operand. The bench also checks that the registered outputs hold between edges and clear while reset is low. A stage that is transparent or clocked on the wrong edge changes its outputs early, and a lost reset leaves stale values.

// File: rtl/negPkg.sv
package negPkg;
  // Strobes that the control side drives into the datapath.
  typedef struct packed {
    logic carrySeed;  // carry injected at the least significant cell
    logic mostNeg;    // operand has no representable negative
  } negCtrl_t;
endpackage

// File: rtl/negSlice.sv
module negSlice (
  input  logic bIn,
  input  logic cIn,
  output logic sum,
  output logic cOut
);
  logic bInv;
  always_comb begin
    bInv = ~bIn;
    sum  = bInv ^ cIn;
    cOut = bInv & cIn;
  end
endmodule

// File: rtl/negControl.sv
module negControl #(
  parameter int N = 4
) (
  input  logic [N-1:0]     b,
  output negPkg::negCtrl_t ctrl
);
  logic isMostNeg;

  generate
    if (N == 1) begin : g_single
      assign isMostNeg = b[0];
    end else begin : g_multi
      assign isMostNeg = b[N-1] & ~(|b[N-2:0]);
    end
  endgenerate

  always_comb begin
    ctrl.carrySeed = 1'b1;
    ctrl.mostNeg   = isMostNeg;
  end
endmodule

// File: rtl/negDatapath.sv
module negDatapath #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     b,
  input  negPkg::negCtrl_t ctrl,
  output logic [N-1:0]     s,
  output logic             cout,
  output logic             ovf
);
  logic [N:0]   carry;
  logic [N-1:0] sumRaw;

  assign carry[0] = ctrl.carrySeed;

  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      negSlice u_cell (
        .bIn (b[i]),
        .cIn (carry[i]),
        .sum (sumRaw[i]),
        .cOut(carry[i+1])
      );
    end

    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          s    <= '0;
          cout <= 1'b0;
          ovf  <= 1'b0;
        end else begin
          s    <= sumRaw;
          cout <= carry[N];
          ovf  <= ctrl.mostNeg;
        end
      end
    end else begin : g_comb
      always_comb begin
        s    = sumRaw;
        cout = carry[N];
        ovf  = ctrl.mostNeg;
      end
    end
  endgenerate
endmodule

// File: rtl/negRipple.sv
module negRipple #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] b,
  output logic [N-1:0] s,
  output logic         cout,
  output logic         ovf
);
  negPkg::negCtrl_t ctrl;

  negControl #(.N(N)) u_ctrl (
    .b   (b),
    .ctrl(ctrl)
  );

  negDatapath #(.N(N), .REG_OUT(REG_OUT)) u_dp (
    .clk (clk),
    .rstN(rstN),
    .b   (b),
    .ctrl(ctrl),
    .s   (s),
    .cout(cout),
    .ovf (ovf)
  );
endmodule

// File: rtl/negRippleChecker.sv
module negRippleChecker #(
  parameter int N       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rstN,
  input logic [N-1:0] b,
  input logic [N-1:0] s,
  input logic         cout,
  input logic         ovf
);
  localparam logic [N-1:0] MOST_NEG = N'(1) << (N - 1);

  logic [N-1:0] refB;
  logic         primed;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          refB   <= '0;
          primed <= 1'b0;
        end else begin
          refB   <= b;
          primed <= 1'b1;
        end
      end
    end else begin : g_comb
      assign refB   = b;
      assign primed = 1'b1;
    end
  endgenerate

  a_r1_negation: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (N'(s + refB) == '0));

  a_r2_carry_zero: assert property (@(posedge clk) disable iff (!rstN)
    (primed && cout) |-> (refB == '0));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (primed && refB != MOST_NEG) |-> !ovf);

  a_r4_most_neg: assert property (@(posedge clk) disable iff (!rstN)
    (primed && refB == MOST_NEG) |-> (ovf && s == refB));

  a_r5_zero: assert property (@(posedge clk) disable iff (!rstN)
    (primed && refB == '0) |-> (cout && s == '0 && !ovf));

  // R7: registered outputs are cleared while reset is held
  always @(negedge clk) begin
    if (REG_OUT && !rstN) begin
      a_r7_reset_clear: assert (s == '0 && !cout && !ovf);
    end
  end
endmodule

bind negRipple negRippleChecker #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk (clk),
  .rstN(rstN),
  .b   (b),
  .s   (s),
  .cout(cout),
  .ovf (ovf)
);

// File: tb/negRipple_bench.sv
module negRipple_bench;
  localparam int W   = 4;
  localparam int MOD = 1 << W;

  typedef struct {
    logic [W-1:0] b;
    logic [W-1:0] s;
    logic         cout;
    logic         ovf;
  } item_t;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] b = '0;
  logic [W-1:0] s;
  logic         cout;
  logic         ovf;

  int    nChecked = 0;
  int    nFailed  = 0;
  item_t q[$];
  item_t lastExp;
  bit    haveLast = 0;

  always #2 clk = ~clk;  // 250 MHz

  negRipple #(.N(W), .REG_OUT(1'b1)) u_negRipple (
    .clk(clk), .rstN(rstN), .b(b), .s(s), .cout(cout), .ovf(ovf)
  );

  function automatic item_t model(logic [W-1:0] v);
    item_t e;
    e.b    = v;
    e.s    = W'((MOD - int'(v)) % MOD);
    e.cout = (v == '0);
    e.ovf  = (int'(v) == MOD / 2);
    return e;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp, logic [W-1:0] opnd);
    nChecked++;
    if (!ok) begin
      nFailed++;
      $display("FAIL %s b=%0h actual=%0h expected=%0h", tag, opnd, act, exp);
    end
  endtask

  // Driver: applies one operand and queues its expected outputs.
  task automatic drive(logic [W-1:0] v);
    @(negedge clk);
    b = v;
    q.push_back(model(v));
    #1;
    // R6: outputs must hold the previous result until the next rising edge
    if (haveLast)
      check(s == lastExp.s && cout == lastExp.cout && ovf == lastExp.ovf,
            "R6 hold-until-edge", int'(s), int'(lastExp.s), v);
  endtask

  // Monitor: compares each result one edge after its operand was driven.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t e;
        string sTag;
        e = q.pop_front();
        sTag = (e.b == '0) ? "R5" : (e.ovf ? "R4" : "R1");
        check(s == e.s, {sTag, " result"}, int'(s), int'(e.s), e.b);
        check(cout == e.cout, "R2 carry-out", int'(cout), int'(e.cout), e.b);
        check(ovf == e.ovf, e.ovf ? "R4 overflow" : "R3 overflow",
              int'(ovf), int'(e.ovf), e.b);
        lastExp  = e;
        haveLast = 1;
      end
    end
  end

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    #2;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        nFailed++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(s == '0 && !cout && !ovf, "R7 reset state", int'({cout, ovf, s}), 0, b);
    @(negedge clk);
    rstN = 1'b1;

    for (int v = 0; v < MOD; v++) drive(W'(v));          // R1 ascending
    for (int v = MOD - 1; v >= 0; v--) drive(W'(v));     // R1 descending
    for (int k = 0; k < 4; k++) begin                    // R4/R5 interleaved
      drive(W'(MOD / 2));
      drive('0);
      drive(W'(MOD - 1));
    end
    drain();

    // R7: asynchronous reset mid-stream
    drive(W'(3));
    drain();
    @(negedge clk);
    #1;
    rstN = 1'b0;
    #0.5;
    check(s == '0 && !cout && !ovf, "R7 async clear", int'({cout, ovf, s}), 0, b);
    repeat (2) @(negedge clk);
    check(s == '0 && !cout && !ovf, "R7 held clear", int'({cout, ovf, s}), 0, b);
    rstN = 1'b1;
    haveLast = 0;

    drive(W'(MOD / 2));  // R4 after reset
    drive('0);           // R5 after reset
    drive(W'(5));
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
    $finish;
  end
endmodule